// File: doc/BRIEF.md
# Prefetching Instruction Queue with Branch Folding

This block is a small circular buffer that separates an instruction fetch path from a dispatch path. The fetch path presents one instruction word per cycle for the address on `fetch_pc`. The queue takes the word whenever instruction memory reports ready and there is space. The dispatch path removes the oldest word each cycle unless it is told to stall. Because the two sides are decoupled, a hazard stall on the dispatch side does not stop fetching, and a memory miss on the fetch side does not stop dispatch while queued work remains.

Branch detection comes from a predecoder one cycle behind the fetch. `branch_seen` therefore refers to the word taken in the previous cycle, and `branch_target` gives that branch's destination. In the cycle `branch_seen` is honoured, the word on the fetch input belongs to the wrong path and is dropped. `fetch_pc` is loaded with the target for the next cycle. If, after this cycle's dispatch, at least one other instruction would stay queued next to the branch, the branch entry is folded. It is taken off the tail of the queue and never appears at dispatch. Otherwise the branch stays queued and is dispatched like any other word.

Top module: `prefetch_iq`

## Requirements
- R1: After reset, `occupancy` is 0, `disp_valid` is 0 and `fetch_pc` equals the `RESET_PC` parameter.
- R2: A word is accepted in a cycle when `fetch_valid` and `mem_ready` are both 1, `occupancy` is below `DEPTH`, and no redirect is being honoured. An accepted word is appended at the tail, and `fetch_pc` rises by `INSTR_BYTES` on the next cycle.
- R3: When `occupancy` equals `DEPTH`, no word is accepted and `fetch_pc` holds.
- R4: `disp_valid` is 1 exactly when `occupancy` is nonzero and `disp_stall` is 0. `disp_word` then shows the oldest queued word, and the words leave in the order they were accepted.
- R5: `occupancy` changes by +1 for each accepted word, by -1 for each dispatched word and by -1 for each folded branch. It stays unchanged in a cycle with one accept and one dispatch.
- R6: While `disp_stall` is 1, nothing is dispatched, but words are still accepted, so `occupancy` rises by one for each stalled cycle that has a fetch.
- R7: While `mem_ready` is 0, no word is accepted and `fetch_pc` holds, but dispatch continues as long as the queue is not empty.
- R8: `branch_seen` is honoured only in the cycle directly after an accepted word. When it is honoured, the word on `fetch_word` in that cycle is discarded and not queued, and `fetch_pc` equals `branch_target` on the next cycle.
- R9: A honoured branch is folded when at least two entries would remain after this cycle's dispatch: the branch and at least one other word. Folding removes the branch entry from the tail, so it is never dispatched.
- R10: A honoured branch that would be the only remaining entry is not folded. It is dispatched in order like an ordinary word.
- R11: `branch_seen` in a cycle that does not follow an accepted word has no effect: the fetch word is accepted normally and `fetch_pc` advances by `INSTR_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A word for `fetch_pc` is present on `fetch_word` |
| fetch_word | input | WORD_W | Instruction word from instruction memory |
| mem_ready | input | 1 | Instruction memory ready (0 during a miss) |
| branch_seen | input | 1 | Predecoder flags the previously accepted word as a branch |
| branch_target | input | ADDR_W | Destination address of the flagged branch |
| disp_stall | input | 1 | Dispatch side cannot take a word this cycle |
| disp_valid | output | 1 | `disp_word` is issued this cycle |
| disp_word | output | WORD_W | Oldest queued instruction word |
| fetch_pc | output | ADDR_W | Address of the word expected on the fetch input |
| occupancy | output | $clog2(DEPTH+1) | Number of queued words |

## Verification
Four stimulus patterns are used. Continuous fetch combined with free dispatch shows that occupancy holds level, which separates a correct two-sided update from one that favours one side. A long dispatch stall with fetch running shows growth up to the full limit and a frozen fetch address there. A memory miss with a non-empty queue shows that dispatch drains independently. For branches, the same flagged word is presented with a deep queue, with a queue that holds only the branch, and with no preceding fetch. These cases tell folding apart from plain dispatch of the branch and from an ignored flag. In each case the dispatched stream is compared word by word against the expected order, and the wrong-path word must never appear.

// File: rtl/piq_pkg.sv
package piq_pkg;

  // Per-cycle queue events decided by the controller.
  typedef struct packed {
    logic push;      // fetch word written at the tail
    logic pop;       // head word issued to dispatch
    logic fold;      // tail branch entry removed
    logic redirect;  // branch flag honoured, fetch path steered
  } q_evt_t;

  // Ring-pointer arithmetic over a buffer of n slots.
  function automatic int ring_next(int p, int n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  function automatic int ring_prev(int p, int n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction

endpackage

// File: rtl/piq_ctrl.sv
module piq_ctrl
  import piq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic             mem_ready,
  input  logic             branch_seen,
  input  logic             disp_stall,
  output q_evt_t           evt,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] FOLD_MIN = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q;
  logic             last_push_q;
  logic [CNT_W-1:0] left_after_pop;

  // Occupancy arithmetic kept in one place.
  function automatic logic [CNT_W-1:0] occ_next(logic [CNT_W-1:0] c, logic in_w,
                                                logic out_w, logic drop_w);
    return c + CNT_W'(in_w) - CNT_W'(out_w) - CNT_W'(drop_w);
  endfunction

  assign left_after_pop = cnt_q - CNT_W'(evt.pop);

  always_comb begin
    evt.redirect = branch_seen & last_push_q;
    evt.pop      = (cnt_q != '0) & ~disp_stall;
    evt.push     = fetch_valid & mem_ready & ~evt.redirect & (cnt_q != FULL_CNT);
    evt.fold     = evt.redirect & (left_after_pop >= FOLD_MIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      last_push_q <= 1'b0;
    end else begin
      cnt_q       <= occ_next(cnt_q, evt.push, evt.pop, evt.fold);
      last_push_q <= evt.push;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/piq_store.sv
module piq_store
  import piq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              fold,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  rd_q;
  logic [PTR_W-1:0]  wr_q;
  logic [PTR_W-1:0]  rd_inc;
  logic [PTR_W-1:0]  wr_inc;
  logic [PTR_W-1:0]  wr_dec;

  assign rd_inc = PTR_W'(ring_next(int'(rd_q), DEPTH));
  assign wr_inc = PTR_W'(ring_next(int'(wr_q), DEPTH));
  assign wr_dec = PTR_W'(ring_prev(int'(wr_q), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (pop) rd_q <= rd_inc;
      // push and fold never coincide: a fold cycle discards the fetch word
      if (push)      wr_q <= wr_inc;
      else if (fold) wr_q <= wr_dec;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_q == PTR_W'(i))) slots[i] <= wdata;
    end
  end

  assign rdata = slots[rd_q];

endmodule

// File: rtl/piq_pc.sv
module piq_pc #(
  parameter int                ADDR_W      = 32,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);

  logic [ADDR_W-1:0] pc_q;

  function automatic logic [ADDR_W-1:0] pc_step(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(INSTR_BYTES);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= RESET_PC;
    else if (redirect) pc_q <= target;
    else if (advance)  pc_q <= pc_step(pc_q);
  end

  assign pc = pc_q;

endmodule

// File: rtl/prefetch_iq.sv
module prefetch_iq
  import piq_pkg::*;
#(
  parameter int                DEPTH       = 8,
  parameter int                WORD_W      = 32,
  parameter int                ADDR_W      = 32,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC    = 32'h0000_0100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fetch_valid,
  input  logic [WORD_W-1:0]            fetch_word,
  input  logic                         mem_ready,
  input  logic                         branch_seen,
  input  logic [ADDR_W-1:0]            branch_target,
  input  logic                         disp_stall,
  output logic                         disp_valid,
  output logic [WORD_W-1:0]            disp_word,
  output logic [ADDR_W-1:0]            fetch_pc,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  q_evt_t evt;

  // Named event wires, observed by the bound checker.
  logic push_fire;
  logic pop_fire;
  logic fold_fire;
  logic redirect_fire;

  assign push_fire     = evt.push;
  assign pop_fire      = evt.pop;
  assign fold_fire     = evt.fold;
  assign redirect_fire = evt.redirect;

  piq_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .mem_ready   (mem_ready),
    .branch_seen (branch_seen),
    .disp_stall  (disp_stall),
    .evt         (evt),
    .count       (occupancy)
  );

  piq_store #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W),
    .PTR_W  (PTR_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_fire),
    .pop   (pop_fire),
    .fold  (fold_fire),
    .wdata (fetch_word),
    .rdata (disp_word)
  );

  piq_pc #(
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .RESET_PC    (RESET_PC)
  ) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (push_fire),
    .redirect (redirect_fire),
    .target   (branch_target),
    .pc       (fetch_pc)
  );

  assign disp_valid = pop_fire;

endmodule

// File: rtl/prefetch_iq_chk.sv
module prefetch_iq_chk #(
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mem_ready,
  input logic                       disp_stall,
  input logic                       disp_valid,
  input logic [ADDR_W-1:0]          branch_target,
  input logic [ADDR_W-1:0]          fetch_pc,
  input logic [$clog2(DEPTH+1)-1:0] occupancy,
  input logic                       push_fire,
  input logic                       pop_fire,
  input logic                       fold_fire,
  input logic                       redirect_fire
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // Set once a full cycle has run out of reset, so $past sees real history.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH)) |-> !push_fire);

  a_r4_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !disp_valid);

  a_r6_stall_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> !disp_valid);

  a_r7_miss_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> !push_fire);

  a_r5_occ_tracks_events: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((occupancy + CNT_W'($past(pop_fire)) + CNT_W'($past(fold_fire)))
               == ($past(occupancy) + CNT_W'($past(push_fire)))));

  a_r2_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(push_fire)) |-> (fetch_pc == $past(fetch_pc) + ADDR_W'(INSTR_BYTES)));

  a_r8_pc_redirected: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(redirect_fire)) |-> (fetch_pc == $past(branch_target)));

  a_r8_wrong_path_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_fire |-> !push_fire);

  a_r9_fold_leaves_work: assert property (@(posedge clk) disable iff (!rst_n)
    fold_fire |-> ((occupancy - CNT_W'(pop_fire)) >= CNT_W'(2)));

endmodule

bind prefetch_iq prefetch_iq_chk #(
  .DEPTH       (DEPTH),
  .ADDR_W      (ADDR_W),
  .INSTR_BYTES (INSTR_BYTES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_ready     (mem_ready),
  .disp_stall    (disp_stall),
  .disp_valid    (disp_valid),
  .branch_target (branch_target),
  .fetch_pc      (fetch_pc),
  .occupancy     (occupancy),
  .push_fire     (push_fire),
  .pop_fire      (pop_fire),
  .fold_fire     (fold_fire),
  .redirect_fire (redirect_fire)
);

// File: tb/prefetch_iq_tb.sv
`timescale 1ns/1ps
module prefetch_iq_tb;

  localparam int          DEPTH = 8;
  localparam int          STEP  = 4;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        mem_ready = 1'b0;
  logic        branch_seen = 1'b0;
  logic [31:0] branch_target = '0;
  logic        disp_stall = 1'b0;
  logic        disp_valid;
  logic [31:0] disp_word;
  logic [31:0] fetch_pc;
  logic [3:0]  occupancy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Scoreboard: words expected to leave the queue, oldest first.
  logic [31:0] exp_q[$];
  logic [31:0] pc_m;
  bit          last_push_m;
  int          seq = 0;

  always #5 clk = ~clk;

  prefetch_iq #(.DEPTH(DEPTH), .RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .mem_ready(mem_ready), .branch_seen(branch_seen), .branch_target(branch_target),
    .disp_stall(disp_stall), .disp_valid(disp_valid), .disp_word(disp_word),
    .fetch_pc(fetch_pc), .occupancy(occupancy)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One cycle: drive, compare against the scoreboard, advance the model.
  task automatic cyc(string req, bit fv, bit mr, bit br, logic [31:0] tgt, bit stall);
    bit exp_v, redir, acc, pop, fold;
    logic [31:0] w;
    @(negedge clk);
    w = 32'hC0DE_0000 + 32'(seq);
    seq++;
    fetch_valid = fv; fetch_word = w; mem_ready = mr;
    branch_seen = br; branch_target = tgt; disp_stall = stall;
    #1;
    exp_v = (exp_q.size() > 0) && !stall;
    chk(req, "occupancy", 32'(occupancy), 32'(exp_q.size()));
    chk(req, "fetch_pc", fetch_pc, pc_m);
    chk(req, "disp_valid", 32'(disp_valid), 32'(exp_v));
    if (exp_v) chk(req, "disp_word", disp_word, exp_q[0]);
    redir = br && last_push_m;
    acc   = fv && mr && (exp_q.size() < DEPTH) && !redir;
    pop   = exp_v;
    fold  = redir && ((exp_q.size() - int'(pop)) >= 2);
    if (pop)  void'(exp_q.pop_front());
    if (fold) void'(exp_q.pop_back());
    if (acc)  exp_q.push_back(w);
    if (redir)    pc_m = tgt;
    else if (acc) pc_m = pc_m + STEP;
    last_push_m = acc;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    pc_m = RST_PC;
    last_push_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "occupancy", 32'(occupancy), 0);
    chk("R1", "disp_valid", 32'(disp_valid), 0);
    chk("R1", "fetch_pc", fetch_pc, RST_PC);

    // R6 R2: dispatch stalled, fetch keeps filling
    for (int i = 0; i < DEPTH; i++) cyc("R6", 1, 1, 0, '0, 1);
    // R3: full, fetch refused and pc holds
    for (int i = 0; i < 3; i++) cyc("R3", 1, 1, 0, '0, 1);
    // R5: fetch and dispatch together keep occupancy level
    for (int i = 0; i < 6; i++) cyc("R5", 1, 1, 0, '0, 0);
    // R7: memory miss, dispatch drains
    for (int i = 0; i < 5; i++) cyc("R7", 1, 0, 0, '0, 0);
    // R4: free dispatch in order until empty
    for (int i = 0; i < 5; i++) cyc("R4", 0, 1, 0, '0, 0);

    // R9: deep queue, branch folded, wrong-path word dropped
    for (int i = 0; i < 3; i++) cyc("R9", 1, 1, 0, '0, 1);
    cyc("R9", 1, 1, 0, '0, 1);                   // branch word accepted
    cyc("R8", 1, 1, 1, 32'h0000_2000, 0);        // honoured with dispatch
    for (int i = 0; i < 2; i++) cyc("R8", 1, 1, 0, '0, 0);
    // R9: fold while stalled with two entries
    cyc("R9", 1, 1, 0, '0, 1);
    cyc("R9", 1, 1, 1, 32'h0000_3000, 1);
    for (int i = 0; i < 6; i++) cyc("R9", 0, 1, 0, '0, 0);

    // R10: branch alone in queue, dispatched in the honouring cycle
    cyc("R10", 1, 1, 0, '0, 0);
    cyc("R10", 1, 1, 1, 32'h0000_4000, 0);
    cyc("R10", 0, 1, 0, '0, 0);
    // R10: branch alone while stalled, stays and is dispatched later
    cyc("R10", 1, 1, 0, '0, 1);
    cyc("R10", 1, 1, 1, 32'h0000_5000, 1);
    for (int i = 0; i < 3; i++) cyc("R10", 0, 1, 0, '0, 0);

    // R11: flag without a preceding accept is ignored
    cyc("R11", 0, 1, 0, '0, 1);
    cyc("R11", 1, 1, 1, 32'h0000_6000, 1);
    cyc("R11", 1, 1, 0, '0, 1);
    for (int i = 0; i < 4; i++) cyc("R4", 0, 1, 0, '0, 0);

    summary();
  end

endmodule